// File: doc/BRIEF.md
# Slot Reservation Gate

This block decides, within the cycle, whether one instruction may claim a proposed set of issue slots or functional units. It holds a reservation vector with one bit per unit for the cycle now being filled. Each attempt proposes one mask. The gate accepts the mask only if all of these hold: no unit in it is already taken, and no programmed relation between unit groups is broken. An accepted mask is merged into the reservation vector at the next clock edge.

There are three kinds of relation, and each kind has a bank of entries. Every entry holds a first group and a second group, both given as unit masks. An exclusion entry keeps the two groups from being active in the same cycle, in either direction. A needs entry lets a unit of the first group be claimed only when some unit of the second group is already held or is claimed in the same request. A forbids entry lets a unit of the first group be claimed only while no unit of the second group is held or claimed.

A new-cycle pulse starts a fresh cycle. A scheduler or issue stage uses the gate to pack instructions into a wide instruction word. Relation masks are loaded through a small write port that works only while the configuration enable is high.

Top module: `slot_gate`

## Requirements
- R1: After reset the reservation vector is zero and every relation mask is zero. Any request with valid high is then accepted.
- R2: A request that names a unit already in the reservation vector is rejected.
- R3: For an exclusion entry, let the combined set be the reservation vector OR the request. The request is rejected if the combined set touches both the first and the second group. This holds whichever group was claimed first.
- R4: For a needs entry (cfg_kind 1), a request that names a unit of the first group is rejected unless the combined set contains a unit of the second group. The rule is one-way: a request naming only second-group units is not restricted by it.
- R5: For a forbids entry (cfg_kind 2), a request that names a unit of the first group is rejected if the combined set contains a unit of the second group. The rule is one-way.
- R6: req_accept is combinational from the request and the current state, and it is low whenever req_valid is low. At the clock edge that follows an accept, the reservation vector becomes its old value OR req_mask.
- R7: A rejected request, or a cycle with req_valid low, leaves the reservation vector unchanged, unless cycle_start is high.
- R8: While cycle_start is high, a request is checked against an empty reservation vector. At the next edge the vector becomes the request mask if the request is accepted, and zero otherwise.
- R9: A relation write takes effect only when both cfg_en and cfg_we are high. When cfg_en is low the write is ignored. cfg_kind selects the bank: 0 is exclusion, 1 is needs, 2 is forbids, and 3 is ignored. cfg_side 0 writes the first group and cfg_side 1 writes the second.
- R10: A bubble request that claims only a middle slot is accepted like any other request. Once accepted, it satisfies a needs entry that a later request for the next slot depends on.
- R11: Every entry of a bank is enforced, whatever its index. An entry with a zero first group or a zero second group has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_start | input | 1 | Starts a fresh reservation cycle |
| req_valid | input | 1 | Request present |
| req_mask | input | N | Units the request wants |
| req_accept | output | 1 | Request may issue this cycle |
| resv | output | N | Units reserved in the current cycle |
| cfg_en | input | 1 | Enables relation writes |
| cfg_we | input | 1 | Relation write strobe |
| cfg_kind | input | 2 | 0 exclusion, 1 needs, 2 forbids |
| cfg_idx | input | IW | Entry index within the bank |
| cfg_side | input | 1 | 0 first group, 1 second group |
| cfg_mask | input | N | Group mask to store |

## Verification
The gate is tried first with no relations programmed, so that only busy-unit conflicts can cause a rejection. It is then tried with one relation kind active at a time. Each relation is driven in both orders of claiming, which separates the two-way exclusion from the one-way needs and forbids rules. Requests that carry both groups at once show that the same-request contribution counts. A gapless three-slot chain, filled through a bubble in the middle slot, together with relation writes attempted while disabled and a new-cycle pulse that arrives with a conflicting request, separates the ordering and enable behaviours.

// File: rtl/slot_gate.sv
module slot_gate #(
  parameter int N    = 8,
  parameter int NREL = 8,
  localparam int IW  = (NREL > 1) ? $clog2(NREL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cycle_start,
  input  logic          req_valid,
  input  logic [N-1:0]  req_mask,
  output logic          req_accept,
  output logic [N-1:0]  resv,
  input  logic          cfg_en,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_kind,
  input  logic [IW-1:0] cfg_idx,
  input  logic          cfg_side,
  input  logic [N-1:0]  cfg_mask
);

  logic [N-1:0] ex_a [NREL];
  logic [N-1:0] ex_b [NREL];
  logic [N-1:0] nd_a [NREL];
  logic [N-1:0] nd_b [NREL];
  logic [N-1:0] fb_a [NREL];
  logic [N-1:0] fb_b [NREL];

  logic [N-1:0] base, comb;
  logic         busy;
  logic [NREL-1:0] ex_bad, nd_bad, fb_bad;

  assign base = cycle_start ? '0 : resv;
  assign comb = base | req_mask;
  assign busy = |(req_mask & base);

  genvar g;
  generate
    for (g = 0; g < NREL; g++) begin : g_rel
      assign ex_bad[g] = (|(comb & ex_a[g])) && (|(comb & ex_b[g]));
      assign nd_bad[g] = (|(req_mask & nd_a[g])) && !(|(comb & nd_b[g]));
      assign fb_bad[g] = (|(req_mask & fb_a[g])) && (|(comb & fb_b[g]));
    end
  endgenerate

  assign req_accept = req_valid && !busy && (ex_bad == '0) && (nd_bad == '0) && (fb_bad == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      resv <= '0;
    else if (cycle_start)
      resv <= req_accept ? req_mask : '0;
    else if (req_accept)
      resv <= resv | req_mask;
  end

  logic wr_ok;
  assign wr_ok = cfg_en && cfg_we && (32'(cfg_idx) < NREL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREL; i++) begin
        ex_a[i] <= '0; ex_b[i] <= '0;
        nd_a[i] <= '0; nd_b[i] <= '0;
        fb_a[i] <= '0; fb_b[i] <= '0;
      end
    end else if (wr_ok) begin
      case (cfg_kind)
        2'd0: if (cfg_side) ex_b[cfg_idx] <= cfg_mask; else ex_a[cfg_idx] <= cfg_mask;
        2'd1: if (cfg_side) nd_b[cfg_idx] <= cfg_mask; else nd_a[cfg_idx] <= cfg_mask;
        2'd2: if (cfg_side) fb_b[cfg_idx] <= cfg_mask; else fb_a[cfg_idx] <= cfg_mask;
        default: ;
      endcase
    end
  end

  assert_busy_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cycle_start && |(req_mask & resv)) |-> !req_accept);

  assert_no_accept_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_accept);

  assert_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_accept && !cycle_start) |=> resv == ($past(resv) | $past(req_mask)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_accept && !cycle_start) |=> $stable(resv));

  assert_fresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> resv == ($past(req_accept) ? $past(req_mask) : '0));

endmodule

// File: tb/tb_slot_gate.sv
module tb_slot_gate;
  localparam int N = 8;
  localparam int NREL = 8;
  localparam int IW = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic cycle_start = 0, req_valid = 0;
  logic [N-1:0] req_mask = '0;
  logic req_accept;
  logic [N-1:0] resv;
  logic cfg_en = 0, cfg_we = 0, cfg_side = 0;
  logic [1:0] cfg_kind = '0;
  logic [IW-1:0] cfg_idx = '0;
  logic [N-1:0] cfg_mask = '0;

  always #10 clk = ~clk;

  slot_gate #(.N(N), .NREL(NREL)) dut (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .req_valid(req_valid),
    .req_mask(req_mask), .req_accept(req_accept), .resv(resv), .cfg_en(cfg_en),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_side(cfg_side),
    .cfg_mask(cfg_mask));

  typedef struct {
    bit acc;
    logic [N-1:0] rv;
    string tag;
  } item_t;
  item_t q[$];

  int errors = 0, checks = 0;
  bit [N-1:0] m_a [3][NREL];
  bit [N-1:0] m_b [3][NREL];
  bit [N-1:0] m_resv = '0;

  function automatic bit model_ok(bit [N-1:0] m, bit cs);
    bit [N-1:0] st = cs ? '0 : m_resv;
    bit [N-1:0] all = st | m;
    if ((m & st) != 0) return 0;
    for (int i = 0; i < NREL; i++) begin
      if ((all & m_a[0][i]) != 0 && (all & m_b[0][i]) != 0) return 0;
      if ((m & m_a[1][i]) != 0 && (all & m_b[1][i]) == 0) return 0;
      if ((m & m_a[2][i]) != 0 && (all & m_b[2][i]) != 0) return 0;
    end
    return 1;
  endfunction

  task automatic attempt(input bit v, input bit [N-1:0] m, input bit cs, input string tag);
    item_t it;
    @(negedge clk);
    req_valid = v; req_mask = m; cycle_start = cs;
    it.acc = v && model_ok(m, cs);
    if (cs) m_resv = it.acc ? m : '0;
    else if (it.acc) m_resv = m_resv | m;
    it.rv = m_resv;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cfg_write(input bit en, input bit [1:0] k, input int idx, input bit side,
                           input bit [N-1:0] m);
    @(negedge clk);
    req_valid = 0; cycle_start = 0;
    cfg_en = en; cfg_we = 1; cfg_kind = k; cfg_idx = IW'(idx); cfg_side = side; cfg_mask = m;
    if (en && k != 2'd3) begin
      if (side) m_b[k][idx] = m; else m_a[k][idx] = m;
    end
    @(negedge clk);
    cfg_we = 0; cfg_en = 0;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #8;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (req_accept !== it.acc) begin
          errors++;
          $display("FAIL %s accept got %0b expected %0b", it.tag, req_accept, it.acc);
        end
        @(posedge clk);
        #2;
        checks++;
        if (resv !== it.rv) begin
          errors++;
          $display("FAIL %s resv got %h expected %h", it.tag, resv, it.rv);
        end
      end
    end
  end

  initial begin : watchdog
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (resv !== '0) begin
      errors++;
      $display("FAIL R1 reset resv got %h expected 00", resv);
    end
    attempt(1, 8'h0F, 1, "R1");
    attempt(1, 8'h10, 0, "R6");
    attempt(1, 8'h01, 0, "R2");
    attempt(0, 8'h20, 0, "R7");
    attempt(1, 8'h03, 1, "R8");
    attempt(0, 8'h00, 1, "R8");
    cfg_write(0, 2'd0, 0, 0, 8'h01);
    cfg_write(0, 2'd0, 0, 1, 8'h02);
    attempt(1, 8'h03, 1, "R9");
    cfg_write(1, 2'd0, 0, 0, 8'h01);
    cfg_write(1, 2'd0, 0, 1, 8'h02);
    attempt(1, 8'h01, 1, "R3");
    attempt(1, 8'h02, 0, "R3");
    attempt(1, 8'h02, 1, "R3");
    attempt(1, 8'h01, 0, "R3");
    attempt(1, 8'h03, 1, "R3");
    cfg_write(1, 2'd0, 0, 0, 8'h00);
    attempt(1, 8'h03, 1, "R11");
    cfg_write(1, 2'd1, 0, 0, 8'h20);
    cfg_write(1, 2'd1, 0, 1, 8'h10);
    cfg_write(1, 2'd1, 1, 0, 8'h40);
    cfg_write(1, 2'd1, 1, 1, 8'h20);
    attempt(1, 8'h20, 1, "R4");
    attempt(1, 8'h30, 1, "R4");
    attempt(1, 8'h10, 1, "R4");
    attempt(1, 8'h40, 0, "R4");
    attempt(1, 8'h20, 0, "R10");
    attempt(1, 8'h40, 0, "R10");
    cfg_write(1, 2'd2, 2, 0, 8'h01);
    cfg_write(1, 2'd2, 2, 1, 8'h06);
    attempt(1, 8'h02, 1, "R5");
    attempt(1, 8'h01, 0, "R5");
    attempt(1, 8'h01, 1, "R5");
    attempt(1, 8'h02, 0, "R5");
    attempt(1, 8'h05, 1, "R5");
    cfg_write(1, 2'd3, 3, 0, 8'h08);
    cfg_write(1, 2'd0, 7, 0, 8'h80);
    cfg_write(1, 2'd0, 7, 1, 8'h08);
    attempt(1, 8'h80, 1, "R11");
    attempt(1, 8'h08, 0, "R11");
    attempt(1, 8'h08, 1, "R9");
    attempt(0, 8'h00, 0, "R7");
    wait (q.size() == 0);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule